// File: doc/BRIEF.md
# DRAM idle power-state sequencer

This block sits beside a DRAM controller in the half-rate interface clock domain. It watches a single bus-activity input and counts how many consecutive cycles the memory bus has been idle. As the count grows past programmed thresholds, it moves the attached memory into progressively deeper low-power states and drives the matching request and clock-gate outputs. From shallowest to deepest the states are:

- power-down;
- self-refresh;
- a lite self-refresh power-down state, available on LPDDR4 only;
- self-refresh with the controller clock gated;
- full standby, where the controller, PHY-interface and DRAM clocks are all gated.

Two of the thresholds are counted in raw interface cycles: power-down and standby. The other three are counted in units of 1024 cycles: self-refresh, lite and controller gating. Any thresholds that are reached at the same time are resolved toward the deepest one. A threshold of zero removes that state.

Any bus activity wakes the block. From a low-power state the block moves to an exit state, and the ready output stays low until the controller acknowledges that the exit sequence has finished. The threshold inputs are copied into internal registers only while the block is active. A new setting therefore never disturbs a sequence that is already under way.

Top module: `dram_idle_seq`

## Requirements
- R1: After reset the block is active: `pstate` is 0, `ready` is 1, and all request and gate outputs are 0.
- R2: `req_pd` rises at the clock edge that completes `cfg_pd_idle` consecutive idle cycles, where idle means `bus_busy` is low. It is not set one edge earlier.
- R3: Self-refresh (`req_sr`, `pstate`=2) is entered at the edge that completes `cfg_sr_idle`×1024 idle cycles.
- R4: Self-refresh with controller clock gating (`pstate`=4, `req_sr` and `gate_mc_clk` high) is entered at `cfg_cg_idle`×1024 idle cycles.
- R5: The lite state (`pstate`=3, `req_lite` high) is entered at `cfg_lite_idle`×1024 idle cycles, and only when `dram_kind` is 2'b10 (LPDDR4). With 2'b00 (DDR3), 2'b01 (LPDDR3) or 2'b11 (reserved), the lite threshold has no effect.
- R6: Standby (`pstate`=5) is entered at `cfg_stby_idle` raw idle cycles. In standby `req_sr`, `gate_mc_clk`, `gate_phy_clk` and `gate_dram_clk` are all high.
- R7: A threshold of 0 disables the transition into its state.
- R8: The depth order is active < power-down < self-refresh < lite < controller-gated < standby. The deepest enabled state whose threshold has been reached is taken, even if this skips intermediate states. While the bus stays idle the state never becomes shallower.
- R9: A cycle with `bus_busy` high clears the idle count. In a low-power state it moves the block to the exit state (`pstate`=6) at that edge, with all requests and gates off. In the active state the block stays active and counting restarts from zero.
- R10: In the exit state `ready` is 0 until `exit_ack` is sampled high. At that edge the block returns to active and `ready` becomes 1.
- R11: Threshold inputs are sampled only in the active state. Changes made in a low-power or exit state take effect only after the block has returned to active.
- R12: The `pstate` encoding is: 0 active, 1 power-down, 2 self-refresh, 3 lite, 4 controller-gated, 5 standby, 6 exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock (half the DRAM clock rate) |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | Bus activity in this cycle |
| exit_ack | input | 1 | Controller finished the low-power exit sequence |
| dram_kind | input | 2 | Memory type: 00 DDR3, 01 LPDDR3, 10 LPDDR4, 11 reserved |
| cfg_pd_idle | input | PD_W | Power-down threshold, raw cycles |
| cfg_sr_idle | input | UNIT_W | Self-refresh threshold, 1024-cycle units |
| cfg_lite_idle | input | UNIT_W | Lite threshold, 1024-cycle units |
| cfg_cg_idle | input | UNIT_W | Controller-gated threshold, 1024-cycle units |
| cfg_stby_idle | input | STBY_W | Standby threshold, raw cycles |
| req_pd | output | 1 | Power-down request |
| req_sr | output | 1 | Self-refresh request |
| req_lite | output | 1 | Lite self-refresh power-down request |
| gate_mc_clk | output | 1 | Gate the controller clock |
| gate_phy_clk | output | 1 | Gate the PHY-interface clock |
| gate_dram_clk | output | 1 | Gate the DRAM clock |
| ready | output | 1 | Block is active and the memory is usable |
| pstate | output | 3 | Current power state code |

## Verification
The sequencer is driven with idle runs that stop exactly one cycle short of a threshold and then continue for one more cycle. This separates an off-by-one count from a correct one, and a raw count from a 1024-scaled one. Threshold sets are chosen so that a shallow state is disabled, several thresholds coincide, or a raw threshold falls below a scaled one. These patterns tell whether zero really disables a state, whether the deepest state wins, and whether the state ever slides back. The same lite setting is tried under LPDDR3 and under LPDDR4 to show that the memory type gates that state. Thresholds are changed in the middle of a low-power state, and a busy cycle is placed just short of the power-down threshold. These show whether the sampled copies are held and whether the idle count restarts.

// File: rtl/dis_pkg.sv
package dis_pkg;

    // Power state codes; the numeric order is the depth order.
    typedef enum logic [2:0] {
        ST_ACT  = 3'd0,
        ST_PD   = 3'd1,
        ST_SR   = 3'd2,
        ST_LITE = 3'd3,
        ST_SRCG = 3'd4,
        ST_STBY = 3'd5,
        ST_EXIT = 3'd6
    } pstate_e;

    typedef enum logic [1:0] {
        MEM_DDR3 = 2'd0,
        MEM_LP3  = 2'd1,
        MEM_LP4  = 2'd2,
        MEM_RSV  = 2'd3
    } mem_kind_e;

    // Threshold levels: level i leads to state i+1.
    localparam int NLVL     = 5;
    localparam int LITE_LVL = 2;
    localparam int NUNIT    = 3;   // scaled levels: SR, LITE, SRCG

    typedef struct packed {
        logic req_pd;
        logic req_sr;
        logic req_lite;
        logic gate_mc;
        logic gate_phy;
        logic gate_dram;
    } pwr_ctl_t;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic pwr_ctl_t decode_ctl(pstate_e s);
        pwr_ctl_t c;
        c           = '0;
        c.req_pd    = (s == ST_PD);
        c.req_sr    = (s == ST_SR) || (s == ST_LITE) || (s == ST_SRCG) || (s == ST_STBY);
        c.req_lite  = (s == ST_LITE);
        c.gate_mc   = (s == ST_SRCG) || (s == ST_STBY);
        c.gate_phy  = (s == ST_STBY);
        c.gate_dram = (s == ST_STBY);
        return c;
    endfunction

endpackage

// File: rtl/dis_thr_bank.sv
module dis_thr_bank
    import dis_pkg::*;
#(
    parameter int PD_W       = 8,
    parameter int UNIT_W     = 8,
    parameter int STBY_W     = 16,
    parameter int UNIT_SHIFT = 10,
    parameter int CNT_W      = 19
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sample,
    input  logic [PD_W-1:0]              cfg_pd,
    input  logic [NUNIT-1:0][UNIT_W-1:0] cfg_unit,
    input  logic [STBY_W-1:0]            cfg_sb,
    output logic [NLVL-1:0][CNT_W-1:0]   thr
);

    logic [PD_W-1:0]              pd_q;
    logic [NUNIT-1:0][UNIT_W-1:0] unit_q;
    logic [STBY_W-1:0]            sb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q   <= '0;
            unit_q <= '0;
            sb_q   <= '0;
        end else if (sample) begin
            pd_q   <= cfg_pd;
            unit_q <= cfg_unit;
            sb_q   <= cfg_sb;
        end
    end

    // Scaling is pure wiring: raw fields are stored, shifted on the way out.
    assign thr[0]      = CNT_W'(pd_q);
    assign thr[NLVL-1] = CNT_W'(sb_q);
    for (genvar j = 0; j < NUNIT; j++) begin : g_unit
        assign thr[j+1] = CNT_W'({unit_q[j], {UNIT_SHIFT{1'b0}}});
    end

    // R11: copies do not move outside the active state
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable({pd_q, unit_q, sb_q}));

endmodule

// File: rtl/dis_idle_ctr.sv
module dis_idle_ctr #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_n
);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (clear)
            cnt_n = '0;
        else if (cnt_q == {CNT_W{1'b1}})
            cnt_n = cnt_q;
        else
            cnt_n = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_n;
    end

    // R9: activity restarts the idle count
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R2: each idle cycle adds exactly one
    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        (!clear && cnt_q != {CNT_W{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/dis_lvl_sel.sv
module dis_lvl_sel
    import dis_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NLVL-1:0][CNT_W-1:0] thr,
    input  logic                       lite_ok,
    output pstate_e                    target
);

    logic [NLVL-1:0] hit;

    for (genvar i = 0; i < NLVL; i++) begin : g_hit
        if (i == LITE_LVL) begin : g_lite
            assign hit[i] = lite_ok && (thr[i] != '0) && (cnt >= thr[i]);
        end else begin : g_plain
            assign hit[i] = (thr[i] != '0) && (cnt >= thr[i]);
        end
    end

    // Deepest reached level wins.
    always_comb begin
        target = ST_ACT;
        for (int i = 0; i < NLVL; i++) begin
            if (hit[i]) target = pstate_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/dis_fsm.sv
module dis_fsm
    import dis_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  logic    exit_ack,
    input  pstate_e target,
    output pstate_e state_q
);

    pstate_e state_d;

    always_comb begin
        state_d = state_q;
        if (state_q == ST_EXIT) begin
            if (exit_ack) state_d = ST_ACT;
        end else if (busy) begin
            state_d = (state_q == ST_ACT) ? ST_ACT : ST_EXIT;
        end else if (target > state_q) begin
            state_d = target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACT;
        else     state_q <= state_d;
    end

    // R9: activity in a low-power state leads to exit
    p_wake_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != ST_ACT && state_q != ST_EXIT) |=> (state_q == ST_EXIT));

    // R10: exit waits for the acknowledge
    p_exit_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXIT && !exit_ack) |=> (state_q == ST_EXIT));

    p_exit_done_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXIT && exit_ack) |=> (state_q == ST_ACT));

    // R8: never shallower while idle continues
    p_no_back_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && state_q != ST_EXIT) |=> (state_q >= $past(state_q)));

endmodule

// File: rtl/dram_idle_seq.sv
module dram_idle_seq
    import dis_pkg::*;
#(
    parameter int PD_W       = 8,
    parameter int UNIT_W     = 8,
    parameter int STBY_W     = 16,
    parameter int UNIT_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy,
    input  logic              exit_ack,
    input  logic [1:0]        dram_kind,
    input  logic [PD_W-1:0]   cfg_pd_idle,
    input  logic [UNIT_W-1:0] cfg_sr_idle,
    input  logic [UNIT_W-1:0] cfg_lite_idle,
    input  logic [UNIT_W-1:0] cfg_cg_idle,
    input  logic [STBY_W-1:0] cfg_stby_idle,
    output logic              req_pd,
    output logic              req_sr,
    output logic              req_lite,
    output logic              gate_mc_clk,
    output logic              gate_phy_clk,
    output logic              gate_dram_clk,
    output logic              ready,
    output logic [2:0]        pstate
);

    localparam int CNT_W = max3(PD_W, UNIT_W + UNIT_SHIFT, STBY_W) + 1;

    pstate_e                    st_q;
    pstate_e                    target;
    pwr_ctl_t                   ctl;
    logic [CNT_W-1:0]           idle_cnt;
    logic [NLVL-1:0][CNT_W-1:0] thr;
    logic                       lite_ok;
    logic                       in_active;

    assign lite_ok   = (dram_kind == MEM_LP4);
    assign in_active = (st_q == ST_ACT);

    dis_thr_bank #(
        .PD_W(PD_W), .UNIT_W(UNIT_W), .STBY_W(STBY_W),
        .UNIT_SHIFT(UNIT_SHIFT), .CNT_W(CNT_W)
    ) u_thr (
        .clk      (clk),
        .rst      (rst),
        .sample   (in_active),
        .cfg_pd   (cfg_pd_idle),
        .cfg_unit ({cfg_cg_idle, cfg_lite_idle, cfg_sr_idle}),
        .cfg_sb   (cfg_stby_idle),
        .thr      (thr)
    );

    dis_idle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (bus_busy || (st_q == ST_EXIT)),
        .cnt_n (idle_cnt)
    );

    dis_lvl_sel #(.CNT_W(CNT_W)) u_sel (
        .cnt     (idle_cnt),
        .thr     (thr),
        .lite_ok (lite_ok),
        .target  (target)
    );

    dis_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .busy     (bus_busy),
        .exit_ack (exit_ack),
        .target   (target),
        .state_q  (st_q)
    );

    assign ctl           = decode_ctl(st_q);
    assign req_pd        = ctl.req_pd;
    assign req_sr        = ctl.req_sr;
    assign req_lite      = ctl.req_lite;
    assign gate_mc_clk   = ctl.gate_mc;
    assign gate_phy_clk  = ctl.gate_phy;
    assign gate_dram_clk = ctl.gate_dram;
    assign ready         = in_active;
    assign pstate        = st_q;

    // R5: the lite state is entered only on LPDDR4
    p_lite_type_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LITE && $past(st_q) != ST_LITE) |-> $past(lite_ok));

    // R6: DRAM clock gating only with every other gate and self-refresh
    p_standby_r6: assert property (@(posedge clk) disable iff (rst)
        gate_dram_clk |-> (gate_mc_clk && gate_phy_clk && req_sr));

    // R10: not ready whenever any request is raised
    p_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (req_pd || req_sr) |-> !ready);

endmodule

// File: tb/sim_dram_idle_seq.sv
module sim_dram_idle_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_busy = 1'b1;
    logic       exit_ack = 1'b0;
    logic [1:0] dram_kind = 2'b00;
    logic [7:0] cfg_pd = '0, cfg_sr = '0, cfg_lite = '0, cfg_cg = '0;
    logic [15:0] cfg_sb = '0;
    logic req_pd, req_sr, req_lite, gate_mc, gate_phy, gate_dram, ready;
    logic [2:0] pstate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dram_idle_seq u0 (
        .clk(clk), .rst(rst), .bus_busy(bus_busy), .exit_ack(exit_ack),
        .dram_kind(dram_kind), .cfg_pd_idle(cfg_pd), .cfg_sr_idle(cfg_sr),
        .cfg_lite_idle(cfg_lite), .cfg_cg_idle(cfg_cg), .cfg_stby_idle(cfg_sb),
        .req_pd(req_pd), .req_sr(req_sr), .req_lite(req_lite),
        .gate_mc_clk(gate_mc), .gate_phy_clk(gate_phy), .gate_dram_clk(gate_dram),
        .ready(ready), .pstate(pstate)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_outs(string req, int st, int pd, int sr, int lt, int mc, int ph, int dr, int rdy);
        chk(req, "pstate", int'(pstate), st);
        chk(req, "outs {pd,sr,lite,mc,phy,dram,ready}",
            int'({req_pd, req_sr, req_lite, gate_mc, gate_phy, gate_dram, ready}),
            int'({pd[0], sr[0], lt[0], mc[0], ph[0], dr[0], rdy[0]}));
    endtask

    // Busy for two edges (active state samples thresholds), then release.
    task automatic prime();
        bus_busy = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_busy = 1'b0;
    endtask

    task automatic idle_for(int n);
        bus_busy = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wake_and_exit(string req);
        bus_busy = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_outs(req, 6, 0, 0, 0, 0, 0, 0, 0);
        bus_busy = 1'b0;
        exit_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        exit_ack = 1'b0;
        chk_outs(req, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic set_cfg(int pd, int sr, int lt, int cg, int sb);
        cfg_pd = 8'(pd); cfg_sr = 8'(sr); cfg_lite = 8'(lt);
        cfg_cg = 8'(cg); cfg_sb = 16'(sb);
    endtask

    task automatic t_reset();
        chk_outs("R1", 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_pd();
        set_cfg(20, 0, 0, 0, 0);
        prime();
        idle_for(19);
        chk_outs("R2", 0, 0, 0, 0, 0, 0, 0, 1);
        idle_for(1);
        chk_outs("R2", 1, 1, 0, 0, 0, 0, 0, 0);
        bus_busy = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_outs("R9", 6, 0, 0, 0, 0, 0, 0, 0);
        bus_busy = 1'b0;
        idle_for(3);
        chk_outs("R10", 6, 0, 0, 0, 0, 0, 0, 0);
        exit_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        exit_ack = 1'b0;
        chk_outs("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_sr();
        set_cfg(20, 1, 0, 0, 0);
        prime();
        idle_for(20);
        chk_outs("R2", 1, 1, 0, 0, 0, 0, 0, 0);
        idle_for(1003);
        chk_outs("R3", 1, 1, 0, 0, 0, 0, 0, 0);
        idle_for(1);
        chk_outs("R3", 2, 0, 1, 0, 0, 0, 0, 0);
        wake_and_exit("R9");
    endtask

    task automatic t_cg_stby();
        set_cfg(0, 0, 0, 2, 3000);
        prime();
        idle_for(1000);
        chk_outs("R7", 0, 0, 0, 0, 0, 0, 0, 1);
        idle_for(1047);
        chk_outs("R7", 0, 0, 0, 0, 0, 0, 0, 1);
        idle_for(1);
        chk_outs("R4", 4, 0, 1, 0, 1, 0, 0, 0);
        idle_for(951);
        chk_outs("R6", 4, 0, 1, 0, 1, 0, 0, 0);
        idle_for(1);
        chk_outs("R6", 5, 0, 1, 0, 1, 1, 1, 0);
        wake_and_exit("R10");
    endtask

    task automatic t_lite();
        set_cfg(0, 1, 2, 3, 0);
        dram_kind = 2'b01;
        prime();
        idle_for(2048);
        chk_outs("R5", 2, 0, 1, 0, 0, 0, 0, 0);
        wake_and_exit("R9");
        dram_kind = 2'b10;
        prime();
        idle_for(2047);
        chk_outs("R5", 2, 0, 1, 0, 0, 0, 0, 0);
        idle_for(1);
        chk_outs("R5", 3, 0, 1, 1, 0, 0, 0, 0);
        idle_for(1024);
        chk_outs("R8", 4, 0, 1, 0, 1, 0, 0, 0);
        wake_and_exit("R12");
        dram_kind = 2'b00;
    endtask

    task automatic t_deepest();
        set_cfg(5, 1, 0, 0, 50);
        prime();
        idle_for(49);
        chk_outs("R8", 1, 1, 0, 0, 0, 0, 0, 0);
        idle_for(1);
        chk_outs("R8", 5, 0, 1, 0, 1, 1, 1, 0);
        idle_for(2000);
        chk_outs("R8", 5, 0, 1, 0, 1, 1, 1, 0);
        wake_and_exit("R10");
    endtask

    task automatic t_sample();
        set_cfg(10, 0, 0, 0, 0);
        prime();
        idle_for(10);
        chk_outs("R11", 1, 1, 0, 0, 0, 0, 0, 0);
        set_cfg(10, 0, 0, 0, 15);
        idle_for(30);
        chk_outs("R11", 1, 1, 0, 0, 0, 0, 0, 0);
        wake_and_exit("R11");
        prime();
        idle_for(15);
        chk_outs("R11", 5, 0, 1, 0, 1, 1, 1, 0);
        wake_and_exit("R11");
    endtask

    task automatic t_restart();
        set_cfg(10, 0, 0, 0, 0);
        prime();
        idle_for(9);
        bus_busy = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_outs("R9", 0, 0, 0, 0, 0, 0, 0, 1);
        idle_for(9);
        chk_outs("R9", 0, 0, 0, 0, 0, 0, 0, 1);
        idle_for(1);
        chk_outs("R9", 1, 1, 0, 0, 0, 0, 0, 0);
        wake_and_exit("R9");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pd();
        t_sr();
        t_cg_stby();
        t_lite();
        t_deepest();
        t_sample();
        t_restart();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule